// File: doc/BRIEF.md
# Product-Term Array with Section Feedback

This block is a combinational sum-of-products array. Its AND plane is programmable and its OR plane is fixed. Each output section owns a fixed group of product terms and ORs only those terms. The defaults are 4 inputs, 4 sections and 3 products per section. Every input and every section output enters the AND plane in true and in complemented form. A function that needs more products than one section holds can therefore be split: a lower section computes part of the sum, and a higher section picks that part up as one literal.

Section feedback only flows upward. Section `s` may use the outputs of sections `0..s-1`. Connection bits that name its own output or a higher section's output are ignored, so the array has no combinational loop. The programming image is shifted in one bit per clock while `load_en` is high. The outputs stay at zero until a complete image has been received.

Top module: `fbk_pal`

## Requirements
- R1: `ready` goes high on the clock edge that takes in the 192nd bit (the default total) of a load. It stays low while fewer bits have been taken in since reset or since the restart of a load.
- R2: While `ready` is low, `out_vec` is all zeros.
- R3: The literal vector of a term is indexed as follows. Index i (0..3) is `in_vec[i]`, 4+i is its complement, 8+k is the output of section k, and 12+k is that output's complement. A term is the AND of its connected literals. The connection bit for section s, term p, literal j is image bit (s*3+p)*16+j. The first bit shifted in becomes image bit 0.
- R4: A term with no effective connected literal evaluates to 0.
- R5: `out_vec[s]` is the OR of the three terms of section s and of no other term.
- R6: A section can use the output of any lower section, in true or in complemented form, as a literal. This allows a four-product function to be built from two sections.
- R7: A connection bit that names the section's own output or a higher section's output is ignored. A term whose only connections are such bits is 0.
- R8: While `load_en` is low, the image and `ready` hold their values and `out_vec` depends only on `in_vec`. A bit taken in while `ready` is high starts a new load and drops `ready`.
- R9: After synchronous active-low reset, `ready` is low and `out_vec` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Shift `cfg_bit` into the image on this edge |
| cfg_bit | input | 1 | Serial programming bit |
| in_vec | input | N_IN | Array inputs |
| out_vec | output | N_SEC | Section outputs, zero until programmed |
| ready | output | 1 | A complete image has been loaded |

## Verification
The first image programs four functions of four inputs, one of which needs four products and so borrows another section's output. All 16 input codes are applied, which separates a correct sum-of-products from one with a wrong literal index, polarity or bit position. The second image uses complemented feedback, self and upward feedback bits that must be ignored, and empty terms. It is also swept exhaustively, which exposes any leak of a forbidden literal. Partial loads, a held image under serial noise, a restarted load and reset show that the outputs are gated by `ready`.

// File: rtl/fbk_pal_pkg.sv
// Package: sizing helpers shared by the array, its loader and the bench.
// Assumes every literal exists in true and complemented form.
package fbk_pal_pkg;

    // Literals seen by one product term.
    function automatic int unsigned term_lits(int unsigned n_in, int unsigned n_sec);
        return 2 * (n_in + n_sec);
    endfunction

    // Total programming bits of the array.
    function automatic int unsigned image_bits(int unsigned n_in, int unsigned n_sec,
                                               int unsigned n_pt);
        return term_lits(n_in, n_sec) * n_sec * n_pt;
    endfunction

endpackage

// File: rtl/fbk_pal_cfg.sv
// Serial image loader: shifts one bit per clock while load_en is high and
// raises ready once a full image has arrived. The first bit ends at index 0.
// Assumes TOTAL > 1.
module fbk_pal_cfg #(
    parameter int unsigned TOTAL = 192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             cfg_bit,
    output logic [TOTAL-1:0] image,
    output logic             ready
);
    localparam int unsigned CNT_W = $clog2(TOTAL);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

    logic [CNT_W-1:0] cnt;

    // Shift the image toward index 0 on every load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       image <= '0;
        else if (load_en) image <= {cfg_bit, image[TOTAL-1:1]};
    end

    // Count bits; the last one of a load sets ready, any other clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (load_en) begin
            if (cnt == LAST) begin
                cnt   <= '0;
                ready <= 1'b1;
            end else begin
                cnt   <= cnt + 1'b1;
                ready <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fbk_pal_array.sv
// AND/OR array: programmable AND plane, fixed OR grouping per section.
// Sections are evaluated in index order, so a section sees only the outputs
// of lower sections. Connections to its own or higher outputs are masked off.
module fbk_pal_array
    import fbk_pal_pkg::*;
#(
    parameter int unsigned N_IN  = 4,
    parameter int unsigned N_SEC = 4,
    parameter int unsigned N_PT  = 3
) (
    input  logic [image_bits(N_IN, N_SEC, N_PT)-1:0] image,
    input  logic [N_IN-1:0]                           in_vec,
    output logic [N_SEC-1:0]                          sec_y
);
    localparam int unsigned LITS = term_lits(N_IN, N_SEC);
    localparam int unsigned FB_T = 2 * N_IN;
    localparam int unsigned FB_C = 2 * N_IN + N_SEC;

    // Connections section s may use: all inputs plus feedback from below s.
    function automatic logic [LITS-1:0] allow_mask(int unsigned s);
        logic [LITS-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < 2 * N_IN; i++) m[i] = 1'b1;
        for (int unsigned k = 0; k < N_SEC; k++) begin
            if (k < s) begin
                m[FB_T + k] = 1'b1;
                m[FB_C + k] = 1'b1;
            end
        end
        return m;
    endfunction

    // Evaluate sections bottom-up, ORing each section's own terms.
    always_comb begin : eval_sections
        logic [N_SEC-1:0] y;
        logic [LITS-1:0]  lit;
        logic [LITS-1:0]  conn;
        logic             term;
        y = '0;
        for (int unsigned s = 0; s < N_SEC; s++) begin
            lit = {~y, y, ~in_vec, in_vec};
            for (int unsigned p = 0; p < N_PT; p++) begin
                conn = image[(s * N_PT + p) * LITS +: LITS] & allow_mask(s);
                term = (|conn) & (&(lit | ~conn));
                y[s] = y[s] | term;
            end
        end
        sec_y = y;
    end
endmodule

// File: rtl/fbk_pal.sv
// Top: serial-programmed product-term array with upward section feedback.
// Outputs are held at zero until a complete image has been loaded.
module fbk_pal
    import fbk_pal_pkg::*;
#(
    parameter int unsigned N_IN  = 4,
    parameter int unsigned N_SEC = 4,
    parameter int unsigned N_PT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             cfg_bit,
    input  logic [N_IN-1:0]  in_vec,
    output logic [N_SEC-1:0] out_vec,
    output logic             ready
);
    localparam int unsigned TOTAL = image_bits(N_IN, N_SEC, N_PT);

    logic [TOTAL-1:0] image;
    logic [N_SEC-1:0] sec_y;

    fbk_pal_cfg #(.TOTAL(TOTAL)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .cfg_bit (cfg_bit),
        .image   (image),
        .ready   (ready)
    );

    fbk_pal_array #(.N_IN(N_IN), .N_SEC(N_SEC), .N_PT(N_PT)) array_i (
        .image  (image),
        .in_vec (in_vec),
        .sec_y  (sec_y)
    );

    // Gate the section outputs until the image is complete.
    always_comb out_vec = ready ? sec_y : '0;
endmodule

// File: rtl/fbk_pal_chk.sv
// Checker for fbk_pal: ready sequencing, output gating and image holding.
// Assumes it is bound into fbk_pal.
module fbk_pal_chk #(
    parameter int unsigned N_IN  = 4,
    parameter int unsigned N_SEC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_en,
    input logic [N_IN-1:0]  in_vec,
    input logic [N_SEC-1:0] out_vec,
    input logic             ready
);
    // R2: no output before a full image.
    p_dark_until_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> out_vec == '0);

    // R1: ready only rises on a load edge.
    p_ready_on_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(load_en));

    // R8: ready holds without load strobes.
    p_ready_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(ready));

    // R8: with the image held, equal inputs give equal outputs.
    p_image_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> (!$stable(in_vec) || $stable(out_vec)));

    // R8: a bit taken in while ready starts a new load.
    p_reload_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && load_en) |=> !ready);
endmodule

bind fbk_pal fbk_pal_chk #(.N_IN(N_IN), .N_SEC(N_SEC)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .in_vec  (in_vec),
    .out_vec (out_vec),
    .ready   (ready)
);

// File: tb/fbk_pal_tb_top.sv
// Bench for fbk_pal: loads two images and sweeps all input codes.
module fbk_pal_tb_top;
    localparam int TOTAL = 192;
    localparam int LITS  = 16;
    localparam int NPT   = 3;
    // Input bit positions: A is the index MSB.
    localparam int IA = 3, IB = 2, IC = 1, ID = 0;
    // Expected truth tables (bit v = output for in_vec == v).
    localparam logic [15:0] TT_W = 16'h3004;
    localparam logic [15:0] TT_X = 16'hFF80;
    localparam logic [15:0] TT_Y = 16'h8DFD;
    localparam logic [15:0] TT_Z = 16'h3106;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic       cfg_bit = 1'b0;
    logic [3:0] in_vec = '0;
    logic [3:0] out_vec;
    logic       ready;
    logic [TOTAL-1:0] img;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fbk_pal dut_i (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .cfg_bit(cfg_bit),
        .in_vec(in_vec), .out_vec(out_vec), .ready(ready)
    );

    // Record one check.
    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // Connect literal j of section s, term p (R3 index layout).
    task automatic put(int s, int p, int j);
        img[(s * NPT + p) * LITS + j] = 1'b1;
    endtask

    // Shift the whole image in; R1: ready stays low until the last bit.
    task automatic load_image();
        for (int i = 0; i < TOTAL; i++) begin
            @(negedge clk);
            if (i == TOTAL - 1) begin
                check("R1 ready before last bit", {7'd0, ready}, 8'd0);
                check("R2 outputs while loading", {4'd0, out_vec}, 8'd0);
            end
            load_en = 1'b1;
            cfg_bit = img[i];
        end
        @(negedge clk);
        load_en = 1'b0;
        cfg_bit = 1'b0;
        check("R1 ready after full image", {7'd0, ready}, 8'd1);
    endtask

    function automatic logic [3:0] exp_one(int v);
        return {TT_Z[v], TT_Y[v], TT_X[v], TT_W[v]};
    endfunction

    function automatic logic [3:0] exp_two(int v);
        logic a, d;
        a = v[IA];
        d = v[ID];
        return {1'b0, a & d, ~a, a};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R9 ready after reset", {7'd0, ready}, 8'd0);
        check("R9 outputs after reset", {4'd0, out_vec}, 8'd0);
        rst_n = 1'b1;

        // Image one: W, X, Y and a four-product Z via W feedback (R3, R5, R6).
        img = '0;
        put(0, 0, IA); put(0, 0, IB); put(0, 0, 4 + IC);
        put(0, 1, 4 + IA); put(0, 1, 4 + IB); put(0, 1, IC); put(0, 1, 4 + ID);
        put(1, 0, IA);
        put(1, 1, IB); put(1, 1, IC); put(1, 1, ID);
        put(2, 0, 4 + IA); put(2, 0, IB);
        put(2, 1, IC); put(2, 1, ID);
        put(2, 2, 4 + IB); put(2, 2, 4 + ID);
        put(3, 0, 8 + 0);
        put(3, 1, IA); put(3, 1, 4 + IC); put(3, 1, 4 + ID);
        put(3, 2, 4 + IA); put(3, 2, 4 + IB); put(3, 2, 4 + IC); put(3, 2, ID);
        load_image();
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            in_vec = 4'(v);
            #1 check("R3 R5 R6 image one sweep", {4'd0, out_vec}, {4'd0, exp_one(v)});
        end

        // R8: serial noise with load_en low changes nothing.
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            cfg_bit = ~cfg_bit;
            in_vec  = 4'(i);
        end
        @(negedge clk);
        check("R8 ready held", {7'd0, ready}, 8'd1);
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            in_vec = 4'(v);
            #1 check("R8 image held", {4'd0, out_vec}, {4'd0, exp_one(v)});
        end

        // R8: a new bit while ready restarts the load; R2 gating follows.
        @(negedge clk);
        load_en = 1'b1;
        cfg_bit = 1'b0;
        @(negedge clk);
        load_en = 1'b0;
        check("R8 reload drops ready", {7'd0, ready}, 8'd0);
        in_vec = 4'hF;
        #1 check("R2 outputs after restart", {4'd0, out_vec}, 8'd0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Image two: complement feedback, ignored self/upward bits (R4, R6, R7).
        img = '0;
        put(0, 0, IA);
        put(0, 1, 12 + 0);
        put(1, 0, 12 + 0);
        put(1, 2, 8 + 2);
        put(2, 0, 8 + 0); put(2, 0, ID);
        load_image();
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            in_vec = 4'(v);
            #1 check("R4 R6 R7 image two sweep", {4'd0, out_vec}, {4'd0, exp_two(v)});
        end

        // R9: reset in mid-operation clears ready and outputs.
        @(negedge clk);
        rst_n = 1'b0;
        in_vec = 4'h9;
        @(negedge clk);
        check("R9 ready after late reset", {7'd0, ready}, 8'd0);
        check("R9 outputs after late reset", {4'd0, out_vec}, 8'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule